// File: doc/BRIEF.md
# Signed Nibble Seven-Segment Converter

This block turns a 4-bit two's-complement value (-8 to +7) into the drive for one common-anode seven-segment digit and a separate minus indicator. The digit always shows the magnitude of the value (0 to 8). The minus output goes high for negative values, so a discrete LED next to the digit can complete the sign.

The logic is purely combinational. A one-hot minterm decoder with active-low outputs recognises the input code. Each segment cathode is then formed by combining, NAND-style, the decoder lines of the codes in which that segment must light. The decimal point is held dark and the digit anode is held enabled, so the block can drive a single display position directly.

Top module: `signed_nibble_sseg`

## Requirements
- R1: For codes 0000 to 0111 the digit shows the value itself (0 to 7) and `minus` is 0.
- R2: For codes 1000 to 1111 the digit shows the magnitude, 16 minus the code (8 down to 1), and `minus` is 1.
- R3: `seg_n` bit 0 drives segment A, bit 1 B, bit 2 C, bit 3 D, bit 4 E, bit 5 F and bit 6 G. A bit at 0 lights its segment.
- R4: The lit segments per digit are: 0=ABCDEF, 1=BC, 2=ABDEG, 3=ABCDG, 4=BCFG, 5=ACDFG, 6=ACDEFG, 7=ABC, 8=all seven.
- R5: `minus` is active high and equals bit 3 of the input for every code.
- R6: `dp_n` is 1 (decimal point dark) for every input code.
- R7: `anode_en` is 1 (digit selected) for every input code.
- R8: The extreme codes decode correctly: 1111 shows 1 with minus, 1000 shows 8 with minus, and 0111 shows 7 without minus.
- R9: No input code blanks the display: every code lights at least two segments.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| value | input | 4 | Two's-complement value to display |
| seg_n | output | 7 | Segment cathodes A..G, active low |
| dp_n | output | 1 | Decimal point cathode, held high (dark) |
| anode_en | output | 1 | Common anode drive, held high |
| minus | output | 1 | Minus indicator, active high |

## Verification
The positive codes tell the digit patterns apart with the sign held off. The negative codes check the magnitude folding: each must give the same pattern as its positive mirror and also raise minus. The codes 0111, 1000 and 1111 sit at the edges of the folding, where an off-by-one magnitude or a wrong sign-bit choice first shows up. A full sweep of all sixteen codes then compares every segment, the minus line and the two fixed pins against a table the bench builds on its own.

// File: rtl/sseg_pkg.sv
package sseg_pkg;

  localparam int SEG_W = 7;

  // Segment order: bit0=A .. bit6=G, bit set means segment lit.
  function automatic logic [SEG_W-1:0] digit_pattern(input int digit);
    logic [SEG_W-1:0] p;
    case (digit)
      0:       p = 7'b0111111;
      1:       p = 7'b0000110;
      2:       p = 7'b1011011;
      3:       p = 7'b1001111;
      4:       p = 7'b1100110;
      5:       p = 7'b1101101;
      6:       p = 7'b1111101;
      7:       p = 7'b0000111;
      8:       p = 7'b1111111;
      default: p = 7'b0000000;
    endcase
    return p;
  endfunction

  // Magnitude of a two's-complement code of the given width.
  function automatic int code_magnitude(input int code, input int width);
    int span;
    span = 1 << width;
    if (code >= (span >> 1)) return span - code;
    return code;
  endfunction

endpackage

// File: rtl/sseg_minterm_dec.sv
module sseg_minterm_dec #(
  parameter int CODE_W = 4,
  localparam int NCODES = 1 << CODE_W
) (
  input  logic [CODE_W-1:0] code,
  output logic [NCODES-1:0] line_n
);

  // One active-low line per minterm of the input code.
  for (genvar c = 0; c < NCODES; c++) begin : g_line
    assign line_n[c] = (code != CODE_W'(c));
  end

endmodule

// File: rtl/sseg_seg_gate.sv
module sseg_seg_gate #(
  parameter int CODE_W  = 4,
  parameter int SEG_IDX = 0,
  localparam int NCODES = 1 << CODE_W
) (
  input  logic [NCODES-1:0] line_n,
  output logic              cathode_n
);
  import sseg_pkg::*;

  logic [NCODES-1:0] pick_n;

  // Keep the decoder lines of codes that light this segment; tie the rest off.
  for (genvar c = 0; c < NCODES; c++) begin : g_pick
    localparam int MAG = code_magnitude(c, CODE_W);
    localparam logic [SEG_W-1:0] PAT = digit_pattern(MAG);
    if (PAT[SEG_IDX]) begin : g_used
      assign pick_n[c] = line_n[c];
    end else begin : g_unused
      assign pick_n[c] = 1'b1;
    end
  end

  // NAND of active-low minterms gives "lit"; the cathode is its inverse.
  assign cathode_n = &pick_n;

endmodule

// File: rtl/signed_nibble_sseg.sv
module signed_nibble_sseg #(
  parameter int CODE_W = 4,
  localparam int NCODES = 1 << CODE_W,
  localparam int SEG_W  = sseg_pkg::SEG_W
) (
  input  logic [CODE_W-1:0] value,
  output logic [SEG_W-1:0]  seg_n,
  output logic              dp_n,
  output logic              anode_en,
  output logic              minus
);

  logic [NCODES-1:0] line_n;

  sseg_minterm_dec #(.CODE_W(CODE_W)) u_dec (
    .code   (value),
    .line_n (line_n)
  );

  for (genvar s = 0; s < SEG_W; s++) begin : g_seg
    sseg_seg_gate #(.CODE_W(CODE_W), .SEG_IDX(s)) u_gate (
      .line_n    (line_n),
      .cathode_n (seg_n[s])
    );
  end

  assign minus    = value[CODE_W-1];
  assign dp_n     = 1'b1;
  assign anode_en = 1'b1;

endmodule

// File: rtl/signed_nibble_sseg_chk.sv
module signed_nibble_sseg_chk (
  input logic [3:0] value,
  input logic [6:0] seg_n,
  input logic       dp_n,
  input logic       anode_en,
  input logic       minus
);

  always_comb begin
    assert_minus_sign_R5: assert (minus == value[3])
      else $error("minus does not follow sign bit");
    assert_dp_dark_R6: assert (dp_n == 1'b1)
      else $error("decimal point lit");
    assert_anode_on_R7: assert (anode_en == 1'b1)
      else $error("anode not driven");
    assert_never_blank_R9: assert ($countones(~seg_n) >= 2)
      else $error("display nearly blank");
    if (value == 4'b0000) begin
      assert_zero_shape_R1: assert (seg_n == 7'b1000000)
        else $error("zero pattern wrong");
    end
    if (value == 4'b1111) begin
      assert_minus_one_R8: assert (seg_n == 7'b1111001)
        else $error("minus one pattern wrong");
    end
    if (value == 4'b1000) begin
      assert_minus_eight_R8: assert (seg_n == 7'b0000000)
        else $error("minus eight pattern wrong");
    end
  end

endmodule

bind signed_nibble_sseg signed_nibble_sseg_chk u_chk (
  .value    (value),
  .seg_n    (seg_n),
  .dp_n     (dp_n),
  .anode_en (anode_en),
  .minus    (minus)
);

// File: tb/signed_nibble_sseg_tb.sv
module signed_nibble_sseg_tb;

  logic       clk;
  logic       rst_n;
  logic [3:0] value;
  logic [6:0] seg_n;
  logic       dp_n;
  logic       anode_en;
  logic       minus;

  int n_checks = 0;
  int n_fail   = 0;

  signed_nibble_sseg u_dut (
    .value    (value),
    .seg_n    (seg_n),
    .dp_n     (dp_n),
    .anode_en (anode_en),
    .minus    (minus)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Expected lit set, bit0=A .. bit6=G (R3, R4).
  function automatic logic [6:0] lit_of(input int d);
    logic [6:0] r;
    r = 7'd0;
    if (d == 0) r = {1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1};
    if (d == 1) r = {1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0};
    if (d == 2) r = {1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1};
    if (d == 3) r = {1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1};
    if (d == 4) r = {1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0};
    if (d == 5) r = {1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1};
    if (d == 6) r = {1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1};
    if (d == 7) r = {1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1};
    if (d == 8) r = 7'b1111111;
    return r;
  endfunction

  function automatic int mag_of(input logic [3:0] v);
    if (v[3]) return 16 - int'(v);
    return int'(v);
  endfunction

  task automatic check(input string req, input logic [9:0] got, input logic [9:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic apply(input logic [3:0] v);
    @(posedge clk);
    value = v;
    @(negedge clk);
  endtask

  task automatic check_code(input string req, input logic [3:0] v);
    logic [6:0] exp_seg;
    apply(v);
    exp_seg = ~lit_of(mag_of(v));
    check(req, {3'b0, seg_n}, {3'b0, exp_seg});
    check(req, {9'b0, minus}, {9'b0, v[3]});
  endtask

  task automatic test_reset_state();
    @(negedge clk);
    check("R1 reset digit", {3'b0, seg_n}, {3'b0, 7'b1000000});
    check("R5 reset minus", {9'b0, minus}, 10'd0);
  endtask

  task automatic test_positive();
    for (int i = 1; i < 8; i++) check_code("R1 positive", 4'(i));
  endtask

  task automatic test_negative();
    for (int i = 9; i < 16; i++) check_code("R2 negative", 4'(i));
  endtask

  task automatic test_extremes();
    apply(4'b1111);
    check("R8 minus one", {2'b0, minus, seg_n}, {2'b0, 1'b1, 7'b1111001});
    apply(4'b1000);
    check("R8 minus eight", {2'b0, minus, seg_n}, {2'b0, 1'b1, 7'b0000000});
    apply(4'b0111);
    check("R8 plus seven", {2'b0, minus, seg_n}, {2'b0, 1'b0, 7'b1111000});
  endtask

  task automatic test_sweep();
    for (int i = 0; i < 16; i++) begin
      apply(4'(i));
      check("R3 R4 sweep segments", {3'b0, seg_n}, {3'b0, ~lit_of(mag_of(4'(i)))});
      check("R5 sweep minus", {9'b0, minus}, {9'b0, 1'(i >> 3)});
      check("R6 dp dark", {9'b0, dp_n}, 10'd1);
      check("R7 anode on", {9'b0, anode_en}, 10'd1);
      n_checks++;
      if ($countones(~seg_n) < 2) begin
        n_fail++;
        $display("FAIL R9: code %0d lit %0d expected >=2", i, $countones(~seg_n));
      end
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0;
    value = 4'b0000;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    test_reset_state();
    test_positive();
    test_negative();
    test_extremes();
    test_sweep();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule